// File: doc/BRIEF.md
# Host Power State Handshake Sequencer

This block sits between a power-domain controller and the two power management units of a USB host controller, one serving the USB2 port and one serving the USB3 port. A small register bank holds a requested device power state and a wake-event enable. A read-only status register shows the state that each unit currently reports. The units themselves are modelled as simple responders. Each one takes on the requested state after its own programmable delay.

While hibernation mode is flagged, the block turns power-domain events into fixed handshake sequences. A domain-off event issues a D3 request and waits until both units report D3. It then asserts the non-sticky reset. A domain-on event first pulses a wake-interrupt clear, then releases the non-sticky reset, then issues a D0 request and waits until both units report D0. The wait polls the unit states once every `POLL_INT` cycles. After `TIMEOUT_POLLS` polls without a match, a sticky error flag is raised and the sequence carries on. A one-cycle done pulse ends each sequence.

The sequencer states are:

| State | Action |
|-------|--------|
| `S_IDLE` | Waits for an event. |
| `S_OFF_REQ` | Writes the D3 request. |
| `S_OFF_WAIT` | Polls for D3. |
| `S_OFF_RESET` | Asserts the non-sticky reset. |
| `S_ON_CLR` | Pulses the wake clear. |
| `S_ON_RELEASE` | Releases the reset. |
| `S_ON_REQ` | Writes the D0 request. |
| `S_ON_WAIT` | Polls for D0. |
| `S_FINISH` | Pulses done. |

The transitions are:

- `S_IDLE` goes to `S_OFF_REQ` on an off event with hibernation set. An off event wins over an on event that arrives in the same cycle.
- `S_IDLE` goes to `S_ON_CLR` on an on event with hibernation set.
- `S_OFF_REQ` goes to `S_OFF_WAIT`.
- `S_OFF_WAIT` goes to `S_OFF_RESET` on a poll that either matches or is the last one allowed.
- `S_OFF_RESET` goes to `S_FINISH`.
- `S_ON_CLR` goes to `S_ON_RELEASE`.
- `S_ON_RELEASE` goes to `S_ON_REQ`.
- `S_ON_REQ` goes to `S_ON_WAIT`.
- `S_ON_WAIT` goes to `S_FINISH` on a poll that either matches or is the last one allowed.
- `S_FINISH` goes to `S_IDLE`.

Top module: `pmu_handshake_seq`

## Requirements
- R1: After reset, the following all read zero: both registers, every output, and both unit states.
- R2: The status register is at offset 0x0 and is read-only. It holds the USB2 unit state in bits [1:0] and the USB3 unit state in bits [4:3]. Writes to it are ignored. All other bits read zero, and unmapped offsets (for example 0x8) read zero.
- R3: The configuration register is at offset 0x4. It holds the power-state request in bits [5:4] and the wake-event enable in bit 3, and all other bits read zero. The state code is 0 for D0 and 3 for D3. Each unit takes on the requested state after its delay.
- R4: While hibernation mode is low, domain events have no effect: no done pulse, no wake clear, no reset change and no register change.
- R5: A domain-off event writes a D3 request first. The non-sticky reset is asserted only after that request has completed.
- R6: Every request issued by the sequencer sets the wake-event enable bit together with the request field.
- R7: A request completes only when both unit states equal the requested value. While one unit lags, the non-sticky reset does not change.
- R8: A domain-on event pulses the wake clear, then deasserts the non-sticky reset, then writes a D0 request. Done follows once both units report D0.
- R9: After `TIMEOUT_POLLS` polls without a match, the error flag is set and the sequence completes anyway. The flag stays high until reset.
- R10: The done output is high for exactly one cycle at the end of each sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| hib_mode | input | 1 | Hibernation flag; enables sequencing |
| dom_off_evt | input | 1 | Power-domain-off event pulse |
| dom_on_evt | input | 1 | Power-domain-on event pulse |
| usb2_delay | input | DLY_W | Response delay of the USB2 unit model, in cycles |
| usb3_delay | input | DLY_W | Response delay of the USB3 unit model, in cycles |
| wake_clr | output | 1 | One-cycle pulse that clears pending wake interrupts |
| nonsticky_rst | output | 1 | Non-sticky reset, active high |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |
| seq_err | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with `POLL_INT` = 2 and keeps `TIMEOUT_POLLS` at its default of 1000, so a timeout occurs about 2000 cycles after a request. A unit delay of 5000 cycles therefore reaches the error path within the run. Uneven delays (2 and 60 cycles) hold one unit back long enough to show that the reset waits for the slower unit.

// File: rtl/pmhs_pkg.sv
package pmhs_pkg;
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_CONFIG = 4;
    localparam int unsigned NUM_UNITS  = 2;

    localparam logic [1:0] PS_D0 = 2'd0;
    localparam logic [1:0] PS_D3 = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OFF_REQ,
        S_OFF_WAIT,
        S_OFF_RESET,
        S_ON_CLR,
        S_ON_RELEASE,
        S_ON_REQ,
        S_ON_WAIT,
        S_FINISH
    } seq_state_e;
endpackage

// File: rtl/pmhs_unit_model.sv
module pmhs_unit_model #(
    parameter int unsigned DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       target,
    input  logic [DLY_W-1:0] delay,
    output logic [1:0]       cur
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= 2'd0;
            cnt <= '0;
        end else if (cur == target) begin
            cnt <= '0;
        end else if (cnt >= delay) begin
            cur <= target;
            cnt <= '0;
        end else begin
            cnt <= cnt + DLY_W'(1);
        end
    end

    AST_UNIT_MOVES_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur) |-> (cur == $past(target))); // R3
endmodule

// File: rtl/pmhs_poll_timer.sv
module pmhs_poll_timer #(
    parameter int unsigned POLL_INT      = 8,
    parameter int unsigned TIMEOUT_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick,
    output logic expired
);
    localparam int unsigned ICNT_W = $clog2(POLL_INT + 1);
    localparam int unsigned PCNT_W = $clog2(TIMEOUT_POLLS + 1);

    logic [ICNT_W-1:0] icnt;
    logic [PCNT_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icnt <= '0;
            pcnt <= '0;
        end else if (!en) begin
            icnt <= '0;
            pcnt <= '0;
        end else if (icnt == ICNT_W'(POLL_INT - 1)) begin
            icnt <= '0;
            if (pcnt != PCNT_W'(TIMEOUT_POLLS))
                pcnt <= pcnt + PCNT_W'(1);
        end else begin
            icnt <= icnt + ICNT_W'(1);
        end
    end

    assign tick    = en && (icnt == ICNT_W'(POLL_INT - 1));
    assign expired = tick && (pcnt == PCNT_W'(TIMEOUT_POLLS - 1));

    AST_POLL_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PCNT_W'(TIMEOUT_POLLS)); // R9
endmodule

// File: rtl/pmhs_regs.sv
module pmhs_regs
    import pmhs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seq_wr,
    input  logic [1:0]        seq_state,
    input  logic [1:0]        u2_cur,
    input  logic [1:0]        u3_cur,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        cfg_req,
    output logic              cfg_wake
);
    logic hit_status;
    logic hit_config;
    logic unused_wdata;

    assign hit_status   = (addr == ADDR_W'(OFS_STATUS));
    assign hit_config   = (addr == ADDR_W'(OFS_CONFIG));
    assign unused_wdata = ^{wdata[DATA_W-1:6], wdata[2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_req  <= PS_D0;
            cfg_wake <= 1'b0;
        end else if (seq_wr) begin
            cfg_req  <= seq_state;
            cfg_wake <= 1'b1;
        end else if (wr && hit_config) begin
            cfg_req  <= wdata[5:4];
            cfg_wake <= wdata[3];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_status) begin
            rdata[1:0] = u2_cur;
            rdata[4:3] = u3_cur;
        end else if (hit_config) begin
            rdata[5:4] = cfg_req;
            rdata[3]   = cfg_wake;
        end
    end

    AST_SEQ_WR_SETS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_wr |=> (cfg_wake && (cfg_req == $past(seq_state)))); // R6
endmodule

// File: rtl/pmhs_fsm.sv
module pmhs_fsm
    import pmhs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hib_mode,
    input  logic       off_evt,
    input  logic       on_evt,
    input  logic       poll_tick,
    input  logic       poll_expired,
    input  logic       match,
    output logic       seq_wr,
    output logic [1:0] seq_state,
    output logic       poll_en,
    output logic       wake_clr,
    output logic       rst_out,
    output logic       done,
    output logic       err
);
    seq_state_e state, state_nx;
    logic waiting;
    logic poll_end;
    logic rst_set;
    logic rst_clr;

    assign waiting  = (state == S_OFF_WAIT) || (state == S_ON_WAIT);
    assign poll_end = poll_tick && (match || poll_expired);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (hib_mode && off_evt)     state_nx = S_OFF_REQ;
                else if (hib_mode && on_evt) state_nx = S_ON_CLR;
            end
            S_OFF_REQ:    state_nx = S_OFF_WAIT;
            S_OFF_WAIT:   if (poll_end) state_nx = S_OFF_RESET;
            S_OFF_RESET:  state_nx = S_FINISH;
            S_ON_CLR:     state_nx = S_ON_RELEASE;
            S_ON_RELEASE: state_nx = S_ON_REQ;
            S_ON_REQ:     state_nx = S_ON_WAIT;
            S_ON_WAIT:    if (poll_end) state_nx = S_FINISH;
            S_FINISH:     state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        seq_wr    = 1'b0;
        seq_state = PS_D0;
        poll_en   = 1'b0;
        wake_clr  = 1'b0;
        rst_set   = 1'b0;
        rst_clr   = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_OFF_REQ: begin
                seq_wr    = 1'b1;
                seq_state = PS_D3;
            end
            S_ON_REQ: begin
                seq_wr    = 1'b1;
                seq_state = PS_D0;
            end
            S_OFF_WAIT, S_ON_WAIT: poll_en = 1'b1;
            S_OFF_RESET:  rst_set  = 1'b1;
            S_ON_CLR:     wake_clr = 1'b1;
            S_ON_RELEASE: rst_clr  = 1'b1;
            S_FINISH:     done     = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rst_out <= 1'b0;
        else if (rst_set) rst_out <= 1'b1;
        else if (rst_clr) rst_out <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err <= 1'b0;
        else if (waiting && poll_tick && !match && poll_expired)
            err <= 1'b1;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9
    AST_HIB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !hib_mode) |=> (state == S_IDLE)); // R4
endmodule

// File: rtl/pmu_handshake_seq.sv
module pmu_handshake_seq
    import pmhs_pkg::*;
#(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned DLY_W         = 16,
    parameter int unsigned POLL_INT      = 8,
    parameter int unsigned TIMEOUT_POLLS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hib_mode,
    input  logic              dom_off_evt,
    input  logic              dom_on_evt,
    input  logic [DLY_W-1:0]  usb2_delay,
    input  logic [DLY_W-1:0]  usb3_delay,
    output logic              wake_clr,
    output logic              nonsticky_rst,
    output logic              seq_done,
    output logic              seq_err
);
    logic [1:0]       unit_cur [NUM_UNITS];
    logic [DLY_W-1:0] unit_dly [NUM_UNITS];
    logic [1:0]       cfg_req;
    logic             cfg_wake;
    logic             seq_wr;
    logic [1:0]       seq_state;
    logic             poll_en;
    logic             poll_tick;
    logic             poll_expired;
    logic             all_match;

    assign unit_dly[0] = usb2_delay;
    assign unit_dly[1] = usb3_delay;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        pmhs_unit_model #(.DLY_W(DLY_W)) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .target(cfg_req),
            .delay (unit_dly[g]),
            .cur   (unit_cur[g])
        );
    end

    always_comb begin
        all_match = 1'b1;
        for (int i = 0; i < NUM_UNITS; i++)
            if (unit_cur[i] != cfg_req) all_match = 1'b0;
    end

    pmhs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .seq_wr   (seq_wr),
        .seq_state(seq_state),
        .u2_cur   (unit_cur[0]),
        .u3_cur   (unit_cur[1]),
        .rdata    (reg_rdata),
        .cfg_req  (cfg_req),
        .cfg_wake (cfg_wake)
    );

    pmhs_poll_timer #(.POLL_INT(POLL_INT), .TIMEOUT_POLLS(TIMEOUT_POLLS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (poll_en),
        .tick   (poll_tick),
        .expired(poll_expired)
    );

    pmhs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hib_mode    (hib_mode),
        .off_evt     (dom_off_evt),
        .on_evt      (dom_on_evt),
        .poll_tick   (poll_tick),
        .poll_expired(poll_expired),
        .match       (all_match),
        .seq_wr      (seq_wr),
        .seq_state   (seq_state),
        .poll_en     (poll_en),
        .wake_clr    (wake_clr),
        .rst_out     (nonsticky_rst),
        .done        (seq_done),
        .err         (seq_err)
    );

    AST_RST_RISE_AT_D3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nonsticky_rst) |-> (cfg_req == PS_D3)); // R5
    AST_DONE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !seq_err) |-> all_match); // R7
endmodule

// File: tb/tb_pmu_handshake_seq.sv
module tb_pmu_handshake_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int DLY_W  = 16;

    typedef struct packed {
        logic rst;
        logic err;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              hib_mode = 1'b0;
    logic              dom_off_evt = 1'b0;
    logic              dom_on_evt = 1'b0;
    logic [DLY_W-1:0]  usb2_delay = 16'd3;
    logic [DLY_W-1:0]  usb3_delay = 16'd3;
    logic              wake_clr;
    logic              nonsticky_rst;
    logic              seq_done;
    logic              seq_err;

    int   total = 0;
    int   bad = 0;
    int   done_seen = 0;
    int   wclr_seen = 0;
    int   cyc = 0;
    int   wclr_cyc = 0;
    int   rstfall_cyc = 0;
    logic prev_done = 1'b0;
    logic prev_rst = 1'b0;
    exp_t exp_q[$];

    pmu_handshake_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W),
        .POLL_INT(2), .TIMEOUT_POLLS(1000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hib_mode(hib_mode),
        .dom_off_evt(dom_off_evt), .dom_on_evt(dom_on_evt),
        .usb2_delay(usb2_delay), .usb3_delay(usb3_delay),
        .wake_clr(wake_clr), .nonsticky_rst(nonsticky_rst),
        .seq_done(seq_done), .seq_err(seq_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_off();
        @(negedge clk); dom_off_evt = 1'b1;
        @(negedge clk); dom_off_evt = 1'b0;
    endtask

    task automatic pulse_on();
        @(negedge clk); dom_on_evt = 1'b1;
        @(negedge clk); dom_on_evt = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        for (int i = 0; i < 20000; i++) begin
            if (done_seen >= target) return;
            @(negedge clk);
        end
        chk(1'b0, tag, done_seen, target);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (wake_clr) begin
            wclr_seen++;
            wclr_cyc = cyc;
        end
        if (prev_rst && !nonsticky_rst) rstfall_cyc = cyc;
        prev_rst = nonsticky_rst;
        if (prev_done) chk(!seq_done, "R10 done longer than one cycle", seq_done, 0);
        if (seq_done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(nonsticky_rst == e.rst, "R5/R8 reset at done", nonsticky_rst, e.rst);
                chk(seq_err == e.err, "R9 error flag at done", seq_err, e.err);
            end
        end
        prev_done = seq_done;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        int w0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, d); chk(d == 0, "R1 status after reset", d, 0);
        rd(4'h4, d); chk(d == 0, "R1 config after reset", d, 0);
        chk({nonsticky_rst, seq_err, seq_done, wake_clr} == 0, "R1 outputs after reset",
            {nonsticky_rst, seq_err, seq_done, wake_clr}, 0);

        // R2 status read-only, unmapped zero
        wr(4'h0, 32'h1B);
        rd(4'h0, d); chk(d == 0, "R2 status write ignored", d, 0);
        rd(4'h8, d); chk(d == 0, "R2 unmapped offset", d, 0);

        // R3 config fields and unit follow
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); chk(d == 32'h38, "R3 config readback", d, 32'h38);
        repeat (20) @(negedge clk);
        rd(4'h0, d); chk(d == 32'h1B, "R3 units reach D3", d, 32'h1B);
        wr(4'h4, 32'h0);
        repeat (20) @(negedge clk);
        rd(4'h0, d); chk(d == 0, "R3 units back to D0", d, 0);

        // R4 events ignored without hibernation
        hib_mode = 1'b0;
        pulse_off(); pulse_on();
        repeat (40) @(negedge clk);
        chk(nonsticky_rst == 0, "R4 reset unchanged", nonsticky_rst, 0);
        chk(wclr_seen == 0, "R4 no wake clear", wclr_seen, 0);
        chk(done_seen == 0, "R4 no done", done_seen, 0);
        rd(4'h4, d); chk(d == 0, "R4 config unchanged", d, 0);

        // R5 R6 R7 off sequence with one slow unit
        hib_mode = 1'b1;
        usb2_delay = 16'd2; usb3_delay = 16'd60;
        exp_q.push_back('{rst: 1'b1, err: 1'b0});
        pulse_off();
        repeat (30) @(negedge clk);
        chk(nonsticky_rst == 0, "R7 reset held while USB3 lags", nonsticky_rst, 0);
        rd(4'h4, d); chk(d == 32'h38, "R6 D3 request with wake enable", d, 32'h38);
        rd(4'h0, d); chk(d == 32'h03, "R7 only USB2 at D3", d, 32'h03);
        wait_done(1, "R5 off sequence done");
        rd(4'h0, d); chk(d == 32'h1B, "R5 both units D3", d, 32'h1B);
        chk(nonsticky_rst == 1, "R5 reset asserted", nonsticky_rst, 1);

        // R8 on sequence
        usb3_delay = 16'd10;
        w0 = wclr_seen;
        exp_q.push_back('{rst: 1'b0, err: 1'b0});
        pulse_on();
        wait_done(2, "R8 on sequence done");
        chk(wclr_seen == w0 + 1, "R8 one wake clear pulse", wclr_seen, w0 + 1);
        chk(wclr_cyc < rstfall_cyc, "R8 clear before reset release", wclr_cyc, rstfall_cyc);
        rd(4'h4, d); chk(d == 32'h08, "R6 D0 request with wake enable", d, 32'h08);
        rd(4'h0, d); chk(d == 0, "R8 both units D0", d, 0);

        // R9 timeout
        usb3_delay = 16'd5000;
        exp_q.push_back('{rst: 1'b1, err: 1'b1});
        pulse_off();
        wait_done(3, "R9 timed-out off done");
        chk(seq_err == 1, "R9 error raised", seq_err, 1);
        chk(nonsticky_rst == 1, "R9 sequence proceeds", nonsticky_rst, 1);
        usb3_delay = 16'd3;
        exp_q.push_back('{rst: 1'b0, err: 1'b1});
        pulse_on();
        wait_done(4, "R9 on after timeout");
        chk(seq_err == 1, "R9 error sticky", seq_err, 1);
        rd(4'h0, d); chk(d == 0, "R9 units D0 after recovery", d, 0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all expected dones seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule